// File: doc/BRIEF.md
# Load/Store Operation Queue

This block holds data-memory operations that the issue stage has already decoded and prepared but that the single data-memory port has not yet completed. Each slot stores whether the operation is a load or a store, the access size, the effective address (base operand plus immediate, summed when the operation enters), the store data and, for a load, the destination register that the returned data must reach. The oldest slot drives a request/acknowledge port. The request stays up until the memory answers, one or more cycles later.

A successful acknowledgement retires exactly one slot, the oldest. If more slots are waiting, the next one is presented in the following cycle, so there is no idle cycle between accesses. An acknowledgement that carries an error raises an exception in that same cycle and empties the queue. The queue reports its occupancy, including the slot still waiting for its answer, so that a companion result buffer can tag its own entries with the number of memory operations ahead of them. Load data is passed to an output together with its destination register and is not written anywhere inside the block.

Top module: `mem_op_queue`

## Requirements
- R1: After reset `occupancy_o` is 0 and `mem_req_o`, `full_o`, `exc_o` and `ld_valid_o` are low.
- R2: While the queue is not empty, `mem_req_o` is high and the port fields show the oldest slot. `mem_addr_o` equals base plus immediate modulo 2^32. `mem_size_o` is 0 for byte, 1 for halfword and 2 for word. `mem_we_o` is 1 for a store and 0 for a load. `mem_wdata_o` is the stored data. All of these stay stable until an acknowledgement arrives.
- R3: Slots retire in the order they were pushed, exactly one per cycle in which `mem_ack_i`=1, `mem_err_i`=0 and `mem_req_o`=1.
- R4: In a successful acknowledge cycle of a load, `ld_valid_o` is 1, `ld_rd_o` is the recorded destination and `ld_data_o` equals `mem_rdata_i`. `ld_valid_o` is 0 on store acknowledgements and on error acknowledgements.
- R5: After a successful acknowledgement with slots remaining, `mem_req_o` is high in the very next cycle with the next slot's fields.
- R6: With 4 slots held, `full_o` is 1, and a push in that state is dropped: occupancy stays 4 and the dropped operation is never requested.
- R7: A push and a successful acknowledgement in the same cycle leave the occupancy unchanged.
- R8: An acknowledgement with `mem_err_i`=1 drives `exc_o` high in that cycle. At the next edge every slot is discarded, including a push made in that cycle, so `occupancy_o` is 0 and `mem_req_o` is low.
- R9: `occupancy_o` counts the slot awaiting acknowledgement: one push into an empty queue gives `occupancy_o`=1 with `mem_req_o` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Issue stage offers an operation |
| push_is_load_i | input | 1 | 1 = load, 0 = store |
| push_size_i | input | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| push_base_i | input | 32 | Base operand |
| push_imm_i | input | 32 | Immediate offset |
| push_wdata_i | input | 32 | Store data |
| push_rd_i | input | 5 | Load destination register |
| full_o | output | 1 | No slot free; issue must stall |
| occupancy_o | output | 3 | Slots held, including the one in flight |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write enable (store) |
| mem_size_o | output | 2 | Access size code |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Store data |
| mem_ack_i | input | 1 | Memory acknowledgement |
| mem_err_i | input | 1 | Acknowledgement carries an error |
| mem_rdata_i | input | 32 | Load data, valid with the acknowledgement |
| ld_valid_o | output | 1 | Load data returned this cycle |
| ld_rd_o | output | 5 | Destination register of returned data |
| ld_data_o | output | 32 | Returned load data |
| exc_o | output | 1 | Error exception |

## Verification
`exc_o`, `ld_valid_o`, `ld_rd_o` and `ld_data_o` are combinational in the acknowledge cycle. The responder therefore drives `mem_ack_i` at a falling edge and reads these outputs a fraction of a nanosecond later, before the next rising edge. Occupancy, `full_o`, and the next request after a pop or a flush change at the rising edge that follows the stimulus, so they are read at the falling edge one cycle after the push or acknowledgement. The responder's acknowledge latency can be set from 0 to several cycles, which exercises both back-to-back retirement and a held request.

// File: rtl/mem_op_pkg.sv
`timescale 1ns/1ps
package mem_op_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned REG_W  = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic              is_load;
    logic [1:0]        size;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [REG_W-1:0]  rd;
  } mem_op_t;
endpackage

// File: rtl/mem_op_form.sv
`timescale 1ns/1ps
module mem_op_form
  import mem_op_pkg::*;
(
  input  logic              is_load_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_W-1:0]  rd_i,
  output mem_op_t           op_o
);
  always_comb begin
    op_o.is_load = is_load_i;
    op_o.size    = size_i;
    op_o.addr    = base_i + imm_i;
    op_o.wdata   = wdata_i;
    op_o.rd      = rd_i;
  end
endmodule

// File: rtl/mem_op_fifo.sv
`timescale 1ns/1ps
module mem_op_fifo
  import mem_op_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  mem_op_t          op_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output mem_op_t          head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  mem_op_t          slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        slot_q[g] <= '0;
      else if (push_i && !flush_i && wr_ptr_q == PTR_W'(g)) slot_q[g] <= op_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R6
  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0)); // R8
  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i) |=> (count_q == $past(count_q))); // R7
endmodule

// File: rtl/mem_op_port.sv
`timescale 1ns/1ps
module mem_op_port
  import mem_op_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mem_op_t           head_i,
  input  logic              empty_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              pop_o,
  output logic              flush_o,
  output logic              ld_valid_o,
  output logic [REG_W-1:0]  ld_rd_o,
  output logic [DATA_W-1:0] ld_data_o
);
  logic ack_seen;

  assign mem_req_o   = !empty_i;
  assign ack_seen    = mem_ack_i && mem_req_o;
  assign pop_o       = ack_seen && !mem_err_i;
  assign flush_o     = ack_seen && mem_err_i;
  assign mem_we_o    = !head_i.is_load;
  assign mem_size_o  = head_i.size;
  assign mem_addr_o  = head_i.addr;
  assign mem_wdata_o = head_i.wdata;
  assign ld_valid_o  = pop_o && head_i.is_load;
  assign ld_rd_o     = head_i.rd;
  assign ld_data_o   = mem_rdata_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_size_o))); // R2
  AST_NO_LD_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ack_i && mem_err_i) |-> !ld_valid_o); // R4
endmodule

// File: rtl/mem_op_queue.sv
`timescale 1ns/1ps
module mem_op_queue
  import mem_op_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  input  logic              push_is_load_i,
  input  logic [1:0]        push_size_i,
  input  logic [ADDR_W-1:0] push_base_i,
  input  logic [ADDR_W-1:0] push_imm_i,
  input  logic [DATA_W-1:0] push_wdata_i,
  input  logic [REG_W-1:0]  push_rd_i,
  output logic              full_o,
  output logic [CNT_W-1:0]  occupancy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [REG_W-1:0]  ld_rd_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              exc_o
);
  mem_op_t new_op, head_op;
  logic    push_fire, pop, flush, empty;

  assign push_fire = push_valid_i && !full_o;
  assign exc_o     = flush;

  mem_op_form i_form (
    .is_load_i (push_is_load_i),
    .size_i    (push_size_i),
    .base_i    (push_base_i),
    .imm_i     (push_imm_i),
    .wdata_i   (push_wdata_i),
    .rd_i      (push_rd_i),
    .op_o      (new_op)
  );

  mem_op_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_fire),
    .op_i    (new_op),
    .pop_i   (pop),
    .flush_i (flush),
    .head_o  (head_op),
    .count_o (occupancy_o),
    .full_o  (full_o),
    .empty_o (empty)
  );

  mem_op_port i_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_i      (head_op),
    .empty_i     (empty),
    .mem_ack_i   (mem_ack_i),
    .mem_err_i   (mem_err_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_size_o  (mem_size_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pop_o       (pop),
    .flush_o     (flush),
    .ld_valid_o  (ld_valid_o),
    .ld_rd_o     (ld_rd_o),
    .ld_data_o   (ld_data_o)
  );

  AST_OCC_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occupancy_o != '0) == mem_req_o); // R9
  AST_ONE_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_err_i && !push_fire) |=>
      (occupancy_o == $past(occupancy_o) - 1'b1)); // R3
  AST_PUSH_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_fire && !(mem_req_o && mem_ack_i)) |=>
      (occupancy_o == $past(occupancy_o) + 1'b1)); // R9
endmodule

// File: tb/test_mem_op_queue.sv
`timescale 1ns/1ps
module test_mem_op_queue;
  import mem_op_pkg::*;

  typedef struct {
    logic        is_load;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [4:0]  rd;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_is_load = 0;
  logic [1:0] push_size = 0;
  logic [31:0] push_base = 0, push_imm = 0, push_wdata = 0;
  logic [4:0] push_rd = 0;
  logic full, req, we, ld_valid, exc;
  logic [2:0] occ;
  logic [1:0] size;
  logic [31:0] addr, wdata, ld_data;
  logic [4:0] ld_rd;
  logic ack = 0, err = 0;
  logic [31:0] rdata = 0;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  bit resp_en = 0, err_next = 0, err_seen = 0, prev_ok = 0;
  int lat = 0, wait_cnt = 0, ack_num = 0;

  always #2 clk = ~clk;

  mem_op_queue i_mem_op_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(push_valid), .push_is_load_i(push_is_load), .push_size_i(push_size),
    .push_base_i(push_base), .push_imm_i(push_imm), .push_wdata_i(push_wdata),
    .push_rd_i(push_rd), .full_o(full), .occupancy_o(occ),
    .mem_req_o(req), .mem_we_o(we), .mem_size_o(size), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_err_i(err), .mem_rdata_i(rdata),
    .ld_valid_o(ld_valid), .ld_rd_o(ld_rd), .ld_data_o(ld_data), .exc_o(exc)
  );

  task automatic check(input bit ok, input string req_tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, expv);
    end
  endtask

  // driver: offer one operation, record it as expected once it is certain to be taken
  task automatic push_op(input bit ld, input logic [1:0] sz, input logic [31:0] b,
                         input logic [31:0] im, input logic [31:0] wd, input logic [4:0] rd);
    exp_t e;
    @(negedge clk); #1;
    while (full) begin @(negedge clk); #1; end
    push_valid = 1; push_is_load = ld; push_size = sz;
    push_base = b; push_imm = im; push_wdata = wd; push_rd = rd;
    e.is_load = ld; e.size = sz; e.addr = b + im; e.wdata = wd; e.rd = rd;
    exp_q.push_back(e);
    @(posedge clk); #0.5;
    push_valid = 0;
  endtask

  task automatic occ_check(input int expv, input string req_tag);
    check(occ == 3'(expv), req_tag, "occupancy", 64'(occ), 64'(expv));
  endtask

  // monitor / responder
  always @(negedge clk) begin
    ack = 0; err = 0;
    if (prev_ok && rst_n) begin
      prev_ok = 0;
      if (exp_q.size() != 0)
        check(req == 1'b1, "R5", "request right after pop", 64'(req), 64'd1);
    end
    if (rst_n && resp_en && req && wait_cnt >= lat) begin
      exp_t e;
      ack = 1; err = err_next; ack_num++;
      rdata = 32'hA500_0000 + 32'(ack_num);
      wait_cnt = 0;
      #0.5;
      if (exp_q.size() == 0) begin
        check(0, "R6", "request with nothing expected", 64'(addr), 64'd0);
      end else if (err) begin
        check(exc == 1'b1 && ld_valid == 1'b0, "R8", "exc/ld_valid on error ack",
              64'({exc, ld_valid}), 64'b10);
        exp_q.delete();
        err_next = 0; resp_en = 0; err_seen = 1;
      end else begin
        e = exp_q.pop_front();
        check(addr == e.addr && size == e.size && we == !e.is_load && wdata == e.wdata,
              "R2", "head fields addr", 64'(addr), 64'(e.addr));
        check(exc == 1'b0, "R3", "no exc on good ack", 64'(exc), 64'd0);
        if (e.is_load)
          check(ld_valid && ld_rd == e.rd && ld_data == rdata, "R4", "load return rd/data",
                {27'd0, ld_rd, ld_data}, {27'd0, e.rd, rdata});
        else
          check(!ld_valid, "R4", "ld_valid on store", 64'(ld_valid), 64'd0);
        prev_ok = 1;
      end
    end else if (req) begin
      wait_cnt++;
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.2;
    check(occ == 0 && !req && !full && !exc && !ld_valid, "R1", "reset outputs",
          64'({occ, req, full, exc, ld_valid}), 64'd0);
    rst_n = 1;

    // R9: single push, held request
    resp_en = 0;
    push_op(0, SZ_WORD, 32'h1000, 32'h10, 32'hDEAD_BEEF, 5'd0);
    @(negedge clk); #0.2;
    occ_check(1, "R9");
    check(req == 1'b1, "R9", "request with one slot", 64'(req), 64'd1);
    lat = 2; resp_en = 1;
    wait (exp_q.size() == 0);
    @(negedge clk); #0.2;
    occ_check(0, "R3");

    // R2/R4: mixed loads and stores, sizes, wrap-around address, latency 1
    lat = 1;
    push_op(1, SZ_BYTE, 32'hFFFF_FFF0, 32'h20, 32'h0, 5'd7);
    push_op(0, SZ_HALF, 32'h2000, 32'h2, 32'h0000_1234, 5'd3);
    push_op(1, SZ_WORD, 32'h3000, 32'hFFFF_FFFC, 32'h0, 5'd31);
    wait (exp_q.size() == 0);
    @(negedge clk); @(negedge clk);

    // R6: fill, drop an extra push
    resp_en = 0;
    for (int i = 0; i < 4; i++)
      push_op(i[0], 2'(i % 3), 32'h4000 + 32'(i * 16), 32'h4, 32'h5500 + 32'(i), 5'(i + 1));
    @(negedge clk); #0.2;
    check(full == 1'b1, "R6", "full at four", 64'(full), 64'd1);
    occ_check(4, "R6");
    #0.8;
    push_valid = 1; push_is_load = 0; push_base = 32'hBAD0; push_imm = 0;
    @(posedge clk); #0.5; push_valid = 0;
    @(negedge clk); #0.2;
    occ_check(4, "R6");
    // R5: drain back to back with latency 0
    lat = 0; resp_en = 1;
    wait (exp_q.size() == 0);
    @(negedge clk); @(negedge clk); #0.2;
    occ_check(0, "R6");
    check(req == 1'b0, "R6", "dropped push never requested", 64'(req), 64'd0);

    // R7: push and pop together
    resp_en = 0;
    push_op(0, SZ_WORD, 32'h5000, 32'h0, 32'h1111, 5'd0);
    push_op(1, SZ_WORD, 32'h5004, 32'h0, 32'h0, 5'd9);
    lat = 0; resp_en = 1;
    push_op(0, SZ_BYTE, 32'h5008, 32'h1, 32'h22, 5'd0);
    resp_en = 0;
    @(negedge clk); #0.2;
    occ_check(2, "R7");
    resp_en = 1;
    wait (exp_q.size() == 0);
    @(negedge clk); @(negedge clk);

    // R8: error ack flushes, push in that cycle also dropped
    resp_en = 0;
    push_op(0, SZ_WORD, 32'h6000, 32'h0, 32'h3333, 5'd0);
    push_op(1, SZ_HALF, 32'h6010, 32'h2, 32'h0, 5'd4);
    push_op(0, SZ_BYTE, 32'h6020, 32'h3, 32'h44, 5'd0);
    err_next = 1; lat = 0; resp_en = 1;
    @(negedge clk); #1;
    push_valid = 1; push_is_load = 0; push_base = 32'h7000; push_imm = 0;
    @(posedge clk); #0.5; push_valid = 0;
    check(err_seen == 1'b1, "R8", "error ack happened", 64'(err_seen), 64'd1);
    @(negedge clk); #0.2;
    occ_check(0, "R8");
    check(req == 1'b0, "R8", "request after flush", 64'(req), 64'd0);

    // queue usable again after flush
    lat = 1; resp_en = 1;
    push_op(1, SZ_WORD, 32'h8000, 32'h8, 32'h0, 5'd12);
    wait (exp_q.size() == 0);
    @(negedge clk); @(negedge clk); #0.2;
    occ_check(0, "R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule